// File: doc/BRIEF.md
# Polyphonic Keyboard Tone Synthesizer

This block turns a row of key switches into one parallel audio sample word for a resistor-ladder DAC. Every key owns a counter-based divider that produces a square wave at that key's note. The square waves of all held keys are added into one word, so chords sound with no limit on how many keys are held. No processor sits in the signal path.

Two push buttons move every note down or up together, one octave per press. An octave step doubles or halves each divider's terminal count. Each button is synchronized and debounced, so a press of any length gives exactly one step and a short glitch gives none. A volume switch picks between the full mixed word and a quieter copy scaled down by a bit shift.

Top module: `poly_tone_synth`

## Requirements
- R1: After reset the sample output is 0 and the octave index is 4, the middle of the range 0 to 7.
- R2: A single held key k produces a square wave on the sample output with levels 0 and 31, and each level lasts H(k,o) clock cycles. The base values for keys 0 to 7 are 191113, 170262, 151686, 143173, 127551, 113636, 101239 and 95557. Each is shifted right by the DIV_SHIFT parameter to give B(k). H(k,o) is B(k) shifted left by 4-o when o<4, and B(k) shifted right by o-4 otherwise.
- R3: A debounced press of octDownBtn lowers the octave index by one, which doubles every half-period. A press of octUpBtn raises the index by one, which halves every half-period.
- R4: The octave index saturates. Down presses at index 0 and up presses at index 7 leave it unchanged, and the index never moves by more than one per clock.
- R5: A computed half-period below 1 is raised to 1, so the voice toggles every clock.
- R6: A button level must hold for DEB_CYCLES clocks after synchronization to count as a press. A shorter pulse causes no octave step. A press held for any length gives exactly one step.
- R7: Held keys add. With loud volume the sample equals 31 times the number of voices in their high phase, so two keys reach 62.
- R8: With volLoud low the sample is the voice sum shifted right by 2, so one voice gives levels 0 and 7.
- R9: Releasing a key removes its contribution within three clocks and resets its divider. After a new press, the first nonzero sample appears H+2 clocks after the key is applied.
- R10: The sample never exceeds 248, the sum of all eight voices at full amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| keys | input | NUM_KEYS | Key switches, bit k high holds key k |
| octDownBtn | input | 1 | Raw button that lowers the octave |
| octUpBtn | input | 1 | Raw button that raises the octave |
| volLoud | input | 1 | 1 selects full volume, 0 selects the quieter shifted volume |
| sample | output | SAMPLE_W | Mixed sample word for the DAC |

## Verification
The bench measures half-periods for single keys at several octave indices, including both saturation ends and an index where the computed count drops below one. These measurements separate a wrong note table, a wrong shift direction and a missing floor. Button stimulus contrasts short glitches with long holds, which separates debounce faults from edge-detection faults. Two-key chords and a quiet-volume run check the additive mix and the shift scaling through the set of levels that appear. A release-and-repress sequence shows the voice clearing and the divider restarting from its low phase.

// File: rtl/tone_synth_pkg.sv
package tone_synth_pkg;
  localparam int OCT_W     = 3;
  localparam int OCT_MAX   = 7;
  localparam int OCT_MID   = 4;
  localparam int DIV_W     = 24;
  localparam int VOICE_AMP = 31;
  localparam int VOL_SHIFT = 2;

  typedef struct packed {
    logic             loud;
    logic [OCT_W-1:0] octave;
  } ctrlBus_t;

  // Half-period counts for one diatonic octave at 100 MHz; keys past
  // the eighth reuse the table one octave higher.
  function automatic logic [DIV_W-1:0] noteHalfPeriod(input int idx);
    logic [DIV_W-1:0] base;
    case (idx % 8)
      0: base = DIV_W'(191113);
      1: base = DIV_W'(170262);
      2: base = DIV_W'(151686);
      3: base = DIV_W'(143173);
      4: base = DIV_W'(127551);
      5: base = DIV_W'(113636);
      6: base = DIV_W'(101239);
      default: base = DIV_W'(95557);
    endcase
    return base >> (idx / 8);
  endfunction
endpackage

// File: rtl/tone_btn_cond.sv
module tone_btn_cond #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic btnRaw,
  output logic pressPulse
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);

  logic syncA, syncB, debLevel;
  logic [CNT_W-1:0] stableCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA      <= 1'b0;
      syncB      <= 1'b0;
      debLevel   <= 1'b0;
      stableCnt  <= '0;
      pressPulse <= 1'b0;
    end else begin
      syncA      <= btnRaw;
      syncB      <= syncA;
      pressPulse <= 1'b0;
      if (syncB != debLevel) begin
        if (stableCnt == CNT_W'(DEB_CYCLES - 1)) begin
          debLevel   <= syncB;
          stableCnt  <= '0;
          pressPulse <= syncB;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end else begin
        stableCnt <= '0;
      end
    end
  end

  // R6: one press yields a single-cycle step strobe
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pressPulse |=> !pressPulse);
endmodule

// File: rtl/tone_synth_ctrl.sv
module tone_synth_ctrl
  import tone_synth_pkg::*;
#(
  parameter int NUM_KEYS   = 8,
  parameter int DEB_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keys,
  input  logic                octDownBtn,
  input  logic                octUpBtn,
  input  logic                volLoud,
  output logic [NUM_KEYS-1:0] keyEn,
  output ctrlBus_t            ctrlBus
);
  localparam int NUM_BTN = 2;

  logic [NUM_BTN-1:0] btnRaw, btnPulse;
  logic downStep, upStep;
  logic [OCT_W-1:0] octave;
  logic loudQ;

  assign btnRaw   = {octUpBtn, octDownBtn};
  assign downStep = btnPulse[0];
  assign upStep   = btnPulse[1];

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    tone_btn_cond #(.DEB_CYCLES(DEB_CYCLES)) btn_i (
      .clk(clk), .rst(rst), .btnRaw(btnRaw[b]), .pressPulse(btnPulse[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      octave <= OCT_W'(OCT_MID);
      keyEn  <= '0;
      loudQ  <= 1'b0;
    end else begin
      keyEn <= keys;
      loudQ <= volLoud;
      if (downStep) begin
        if (octave != '0) octave <= octave - 1'b1;
      end else if (upStep) begin
        if (octave != OCT_W'(OCT_MAX)) octave <= octave + 1'b1;
      end
    end
  end

  assign ctrlBus.loud   = loudQ;
  assign ctrlBus.octave = octave;

  // R4: the octave moves by at most one step per clock
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    (octave != $past(octave)) |->
      ((octave - $past(octave) == OCT_W'(1)) || ($past(octave) - octave == OCT_W'(1))));

  // R4: saturation at the top of the range
  a_r4_sat_top: assert property (@(posedge clk) disable iff (rst)
    (octave == OCT_W'(OCT_MAX) && upStep && !downStep) |=> (octave == OCT_W'(OCT_MAX)));

  // R4: saturation at the bottom of the range
  a_r4_sat_bottom: assert property (@(posedge clk) disable iff (rst)
    (octave == '0 && downStep) |=> (octave == '0));
endmodule

// File: rtl/tone_voice.sv
module tone_voice #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             keyOn,
  input  logic [DIV_W-1:0] halfPeriod,
  output logic             phase
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !keyOn) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt >= halfPeriod - 1'b1) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: a released key drops to its low phase on the next clock
  a_r9_release_clears: assert property (@(posedge clk) disable iff (rst)
    !keyOn |=> !phase);
endmodule

// File: rtl/tone_synth_dpath.sv
module tone_synth_dpath
  import tone_synth_pkg::*;
#(
  parameter int NUM_KEYS  = 8,
  parameter int DIV_SHIFT = 0,
  parameter int SAMPLE_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keyEn,
  input  ctrlBus_t            ctrlBus,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int MAX_SUM = NUM_KEYS * VOICE_AMP;

  logic [NUM_KEYS-1:0] phase;
  logic [SAMPLE_W-1:0] voiceSum;

  for (genvar i = 0; i < NUM_KEYS; i++) begin : g_voice
    logic [DIV_W-1:0] baseCnt, scaledCnt, limitCnt;

    always_comb begin
      baseCnt = noteHalfPeriod(i) >> DIV_SHIFT;
      if (ctrlBus.octave < OCT_W'(OCT_MID))
        scaledCnt = baseCnt << (OCT_W'(OCT_MID) - ctrlBus.octave);
      else
        scaledCnt = baseCnt >> (ctrlBus.octave - OCT_W'(OCT_MID));
      limitCnt = (scaledCnt == '0) ? DIV_W'(1) : scaledCnt;
    end

    tone_voice #(.DIV_W(DIV_W)) voice_i (
      .clk(clk), .rst(rst), .keyOn(keyEn[i]),
      .halfPeriod(limitCnt), .phase(phase[i])
    );
  end

  always_comb begin
    voiceSum = '0;
    for (int i = 0; i < NUM_KEYS; i++)
      if (phase[i]) voiceSum = voiceSum + SAMPLE_W'(VOICE_AMP);
  end

  always_ff @(posedge clk) begin
    if (rst) sample <= '0;
    else     sample <= ctrlBus.loud ? voiceSum : (voiceSum >> VOL_SHIFT);
  end

  // R10: the mixed word never exceeds all voices at full amplitude
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    sample <= SAMPLE_W'(MAX_SUM));

  // R8: quiet volume bounds the word at the shifted maximum
  a_r8_soft_bound: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrlBus.loud) |-> (sample <= SAMPLE_W'(MAX_SUM >> VOL_SHIFT)));
endmodule

// File: rtl/poly_tone_synth.sv
module poly_tone_synth
  import tone_synth_pkg::*;
#(
  parameter int NUM_KEYS   = 8,
  parameter int DIV_SHIFT  = 0,
  parameter int DEB_CYCLES = 2000000,
  parameter int SAMPLE_W   = $clog2(NUM_KEYS * VOICE_AMP + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keys,
  input  logic                octDownBtn,
  input  logic                octUpBtn,
  input  logic                volLoud,
  output logic [SAMPLE_W-1:0] sample
);
  logic [NUM_KEYS-1:0] keyEn;
  ctrlBus_t ctrlBus;

  tone_synth_ctrl #(.NUM_KEYS(NUM_KEYS), .DEB_CYCLES(DEB_CYCLES)) ctrl_i (
    .clk(clk), .rst(rst), .keys(keys), .octDownBtn(octDownBtn),
    .octUpBtn(octUpBtn), .volLoud(volLoud), .keyEn(keyEn), .ctrlBus(ctrlBus)
  );

  tone_synth_dpath #(.NUM_KEYS(NUM_KEYS), .DIV_SHIFT(DIV_SHIFT), .SAMPLE_W(SAMPLE_W)) dpath_i (
    .clk(clk), .rst(rst), .keyEn(keyEn), .ctrlBus(ctrlBus), .sample(sample)
  );
endmodule

// File: tb/poly_tone_synth_tb.sv
module poly_tone_synth_tb_top;
  localparam int NK = 8;
  localparam int SHIFT = 14;
  localparam int DEB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NK-1:0] keys = '0;
  logic octDownBtn = 1'b0, octUpBtn = 1'b0, volLoud = 1'b1;
  logic [7:0] sample;

  int checks = 0;
  int errors = 0;

  typedef struct { string req; int val; } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;

  poly_tone_synth #(.NUM_KEYS(NK), .DIV_SHIFT(SHIFT), .DEB_CYCLES(DEB)) dut_i (
    .clk(clk), .rst(rst), .keys(keys), .octDownBtn(octDownBtn),
    .octUpBtn(octUpBtn), .volLoud(volLoud), .sample(sample)
  );

  function automatic int halfOf(int k, int oct);
    int tbl[8] = '{191113, 170262, 151686, 143173, 127551, 113636, 101239, 95557};
    int b = tbl[k] >> SHIFT;
    int h = (oct < 4) ? (b << (4 - oct)) : (b >> (oct - 4));
    return (h < 1) ? 1 : h;
  endfunction

  // driver side of the scoreboard
  task automatic expectItem(string r, int v);
    expQ.push_back('{r, v});
  endtask

  // monitor side: pop the oldest expectation and compare
  task automatic scoreActual(int act);
    exp_t e;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL scoreboard empty actual=%0d expected=none", act);
      return;
    end
    e = expQ.pop_front();
    if (act != e.val) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", e.req, act, e.val);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measureHalf(output int h);
    logic [7:0] prev;
    int n;
    h = -1;
    prev = sample;
    n = 0;
    while (sample == prev && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) return;
    prev = sample;
    n = 0;
    while (sample == prev && n < 3000) begin @(negedge clk); n++; end
    if (n < 3000) h = n;
  endtask

  task automatic window(int n, int allowA, int allowB, int allowC,
                        output int mx, output int bad);
    mx = 0; bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (int'(sample) > mx) mx = int'(sample);
      if (int'(sample) != allowA && int'(sample) != allowB && int'(sample) != allowC) bad++;
    end
  endtask

  task automatic pressBtn(bit up, int hold);
    @(negedge clk);
    if (up) octUpBtn = 1'b1; else octDownBtn = 1'b1;
    waitCyc(hold);
    octUpBtn = 1'b0; octDownBtn = 1'b0;
    waitCyc(DEB + 12);
  endtask

  task automatic checkKey(int k, int oct, string r);
    int h;
    @(negedge clk); keys = '0; waitCyc(4);
    keys[k] = 1'b1;
    expectItem(r, halfOf(k, oct));
    measureHalf(h);
    scoreActual(h);
    keys = '0; waitCyc(4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int h, mx, bad, n;
    waitCyc(5);
    // R1: reset state
    expectItem("R1 reset sample", 0);
    scoreActual(int'(sample));
    rst = 1'b0;
    waitCyc(3);
    expectItem("R1 idle sample", 0);
    scoreActual(int'(sample));

    // R1, R2: default octave and per-key half-periods
    checkKey(0, 4, "R1 R2 key0 period oct4");
    checkKey(7, 4, "R2 key7 period oct4");
    keys = 8'h01;
    window(60, 0, 31, 31, mx, bad);
    expectItem("R2 single amplitude", 31); scoreActual(mx);
    expectItem("R2 single levels", 0);     scoreActual(bad);

    // R9: release clears, hold stays silent, repress restarts low
    waitCyc(3); keys = '0;
    waitCyc(4);
    expectItem("R9 release clears", 0); scoreActual(int'(sample));
    window(40, 0, 0, 0, mx, bad);
    expectItem("R9 stays silent", 0); scoreActual(mx);
    keys = 8'h01; n = 0;
    while (sample == 0 && n < 500) begin @(negedge clk); n++; end
    expectItem("R9 restart delay", halfOf(0, 4) + 2); scoreActual(n);
    keys = '0; waitCyc(4);

    // R3: down then up
    pressBtn(1'b0, 20);
    checkKey(0, 3, "R3 down doubles");
    pressBtn(1'b1, 20); pressBtn(1'b1, 20);
    checkKey(0, 5, "R3 up halves");

    // R6: glitch ignored, long hold one step
    pressBtn(1'b1, 3);
    checkKey(0, 5, "R6 glitch ignored");
    pressBtn(1'b1, 80);
    checkKey(0, 6, "R6 long hold one step");

    // R4, R5: top saturation and floor
    for (int i = 0; i < 3; i++) pressBtn(1'b1, 20);
    checkKey(0, 7, "R4 top saturate");
    checkKey(7, 7, "R5 floor to one");

    // R4: bottom saturation
    for (int i = 0; i < 10; i++) pressBtn(1'b0, 20);
    checkKey(0, 0, "R4 bottom saturate");
    for (int i = 0; i < 4; i++) pressBtn(1'b1, 20);

    // R7, R10: two-key chord
    @(negedge clk); keys = 8'h03;
    window(400, 0, 31, 62, mx, bad);
    expectItem("R7 chord peak", 62); scoreActual(mx);
    expectItem("R7 chord levels", 0); scoreActual(bad);
    keys = 8'hFF;
    window(400, 0, 31, 62, mx, bad);
    expectItem("R10 full chord bound", 1); scoreActual((mx <= 248) ? 1 : 0);
    keys = '0; waitCyc(4);

    // R8: quiet volume
    volLoud = 1'b0; keys = 8'h01;
    window(100, 0, 7, 7, mx, bad);
    expectItem("R8 soft peak", 7); scoreActual(mx);
    expectItem("R8 soft levels", 0); scoreActual(bad);
    keys = 8'hFF;
    window(400, 0, 0, 0, mx, bad);
    expectItem("R8 soft chord bound", 1); scoreActual((mx <= 62) ? 1 : 0);
    keys = '0; volLoud = 1'b1; waitCyc(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule